// File: doc/BRIEF.md
# Serial Transmitter with Address/Data Frame Marking

This block sends bytes over an asynchronous serial line. Each frame carries one extra bit after the data byte. A 1 in that bit marks the frame as an address (station ID) frame, and a 0 marks it as a data frame. Receivers on a shared line can use this bit to pick out the frames addressed to them.

Software drives the block through two registers:
- a one-byte holding register for the next byte to send;
- a status/control register holding the holding-register-empty flag, the all-sent flag and the frame-marking control bit.

To send a byte, software checks that the holding register is free, writes the byte, and then clears the empty flag to hand the byte over. While the holding register is free, the block raises an interrupt request. A DMA engine can answer that request by writing the byte on a separate path, and that write hands the byte over without any flag access.

Bit timing comes from a divider that produces one bit boundary every `BIT_CYCLES` clocks. A byte that has been handed over moves into the shifter at the next bit boundary once the shifter is free. Frames therefore follow one another with no idle gap.

Top module: `mpx_uart_tx`

## Requirements
- R1: After reset the line is 1 and the interrupt request is 1. The status register reads empty=1, end=1 and mark=0.
- R2: A frame is, in order:
  - a start bit of 0;
  - 8 data bits, least significant first;
  - the marking bit;
  - a stop bit of 1.
  
  Every bit holds for exactly BIT_CYCLES clocks, and the line rests at 1 between frames.
- R3: The marking bit of a frame equals the mark control bit as it stands when the byte is handed over. Changing the mark control bit afterwards does not alter that frame.
- R4: Register map:
  - address 0 is the holding register;
  - address 1 is status, with bit0 = empty flag, bit1 = end flag (read-only) and bit2 = mark control bit;
  - a write to address 1 always loads bit2 into the mark control bit.
- R5: Writing 0 to bit0 of status clears the empty flag, which hands the byte over. This works only if status was read with bit0=1 since the last hand-over. Without such a read, the write has no effect.
- R6: Writing 1 to bit0 of status has no effect on the empty flag.
- R7: A DMA write while the empty flag is 1 stores the byte and clears the empty flag. A DMA write while the empty flag is 0 is ignored.
- R8: A host write to the holding register while the empty flag is 0 is ignored.
- R9: The interrupt request is 1 exactly while the empty flag is 1.
- R10: When a frame ends and a byte is waiting, the next start bit begins at that same boundary, so consecutive start bits are 11*BIT_CYCLES clocks apart. The empty flag returns to 1 as the byte moves into the shifter.
- R11: The end flag is 1 only when no frame is shifting and no byte is waiting. It returns to 1 once the last frame has shifted out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr_en | input | 1 | Host register write strobe |
| host_rd_en | input | 1 | Host register read strobe (arms the flag clear) |
| host_addr | input | 1 | Register select: 0 holding, 1 status |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Selected register contents (combinational) |
| dma_wr_en | input | 1 | DMA write strobe into the holding register |
| dma_wdata | input | 8 | DMA write data |
| txd | output | 1 | Serial line |
| txi_req | output | 1 | Holding-register-empty interrupt request |

## Verification
The tests cover the following cases:
- **Address frame first.** An address frame followed by data frames checks that the marking bit is taken from the control bit, in both polarities.
- **Edge-value bytes.** The bytes 0x00, 0xFF and mixed patterns show whether the bit order and the start and stop framing are right.
- **Back-to-back hand-overs.** Three bytes handed over back to back separate gapless chaining from restart-on-idle behaviour, by measuring the spacing of the start bits.
- **Invalid hand-overs.** A clear without a prior read, a write of 1, and host and DMA writes while the holding register is full show that only legal hand-overs start a frame.
- **Late change of the control bit.** A DMA hand-over followed by a change of the control bit separates latching at hand-over from latching at load.

// File: rtl/mpx_tx_pkg.sv
package mpx_tx_pkg;

  // status register bit positions
  localparam int STAT_EMPTY = 0;
  localparam int STAT_END   = 1;
  localparam int STAT_MARK  = 2;

  // register select values
  localparam logic ADDR_HOLD = 1'b0;
  localparam logic ADDR_STAT = 1'b1;

  // start + marking bit + stop around the data byte
  localparam int FRAME_OVERHEAD = 3;

  typedef enum logic {
    SH_IDLE = 1'b0,
    SH_RUN  = 1'b1
  } sh_state_t;

endpackage

// File: rtl/mpx_bit_tick.sv
module mpx_bit_tick #(
  parameter int BIT_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (BIT_CYCLES > 1) ? $clog2(BIT_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(BIT_CYCLES - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    tick  = (cnt_q == LAST);
    cnt_d = tick ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/mpx_host_regs.sv
module mpx_host_regs
  import mpx_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr_en,
  input  logic              host_rd_en,
  input  logic              host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  input  logic              dma_wr_en,
  input  logic [DATA_W-1:0] dma_wdata,
  input  logic              load,
  input  logic              busy,
  output logic [DATA_W-1:0] hold_data,
  output logic              hold_mark,
  output logic              empty,
  output logic              tend
);
  logic [DATA_W-1:0] hold_q, hold_d;
  logic empty_q, empty_d;
  logic mark_q, mark_d;
  logic mhold_q, mhold_d;
  logic armed_q, armed_d;
  logic stat_wr, hold_wr, dma_take, host_clear, commit;

  always_comb begin
    stat_wr    = host_wr_en & (host_addr == ADDR_STAT);
    hold_wr    = host_wr_en & (host_addr == ADDR_HOLD);
    dma_take   = dma_wr_en & empty_q;
    host_clear = stat_wr & ~host_wdata[STAT_EMPTY] & armed_q & empty_q & ~dma_wr_en;
    commit     = dma_take | host_clear;

    hold_d  = hold_q;
    empty_d = empty_q;
    mark_d  = mark_q;
    mhold_d = mhold_q;
    armed_d = armed_q;

    if (stat_wr) mark_d = host_wdata[STAT_MARK];

    if (dma_take)                hold_d = dma_wdata;
    else if (hold_wr && empty_q) hold_d = host_wdata;

    if (host_rd_en && host_addr == ADDR_STAT && empty_q) armed_d = 1'b1;

    if (commit) begin
      empty_d = 1'b0;
      armed_d = 1'b0;
      mhold_d = mark_d;
    end
    if (load) empty_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q  <= '0;
      empty_q <= 1'b1;
      mark_q  <= 1'b0;
      mhold_q <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      hold_q  <= hold_d;
      empty_q <= empty_d;
      mark_q  <= mark_d;
      mhold_q <= mhold_d;
      armed_q <= armed_d;
    end
  end

  always_comb begin
    tend       = empty_q & ~busy;
    host_rdata = '0;
    if (host_addr == ADDR_HOLD) begin
      host_rdata = hold_q;
    end else begin
      host_rdata[STAT_EMPTY] = empty_q;
      host_rdata[STAT_END]   = tend;
      host_rdata[STAT_MARK]  = mark_q;
    end
    hold_data = hold_q;
    hold_mark = mhold_q;
    empty     = empty_q;
  end
endmodule

// File: rtl/mpx_tx_shifter.sv
module mpx_tx_shifter
  import mpx_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              empty,
  input  logic [DATA_W-1:0] hold_data,
  input  logic              hold_mark,
  output logic              load,
  output logic              busy,
  output logic              txd
);
  localparam int FW = DATA_W + FRAME_OVERHEAD;
  localparam int BW = $clog2(FW);
  localparam logic [BW-1:0] LAST_BIT = BW'(FW - 1);

  sh_state_t     state_q, state_d;
  logic [FW-1:0] sh_q, sh_d;
  logic [BW-1:0] bit_q, bit_d;
  logic          frame_done;

  always_comb begin
    frame_done = (state_q == SH_RUN) && (bit_q == LAST_BIT);
    load       = tick && !empty && ((state_q == SH_IDLE) || frame_done);

    state_d = state_q;
    sh_d    = sh_q;
    bit_d   = bit_q;

    if (load) begin
      state_d = SH_RUN;
      sh_d    = {1'b1, hold_mark, hold_data, 1'b0};
      bit_d   = '0;
    end else if (tick && frame_done) begin
      state_d = SH_IDLE;
      sh_d    = '1;
      bit_d   = '0;
    end else if (tick && state_q == SH_RUN) begin
      sh_d    = {1'b1, sh_q[FW-1:1]};
      bit_d   = bit_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SH_IDLE;
      sh_q    <= '1;
      bit_q   <= '0;
    end else begin
      state_q <= state_d;
      sh_q    <= sh_d;
      bit_q   <= bit_d;
    end
  end

  always_comb begin
    busy = (state_q == SH_RUN);
    txd  = sh_q[0];
  end
endmodule

// File: rtl/mpx_uart_tx.sv
module mpx_uart_tx #(
  parameter int DATA_W     = 8,
  parameter int BIT_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr_en,
  input  logic              host_rd_en,
  input  logic              host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  input  logic              dma_wr_en,
  input  logic [DATA_W-1:0] dma_wdata,
  output logic              txd,
  output logic              txi_req
);
  logic [1:0] rst_pipe;
  logic       rst_n_int;
  logic       tick, load, busy, empty, tend, hold_mark;
  logic [DATA_W-1:0] hold_data;

  // assert asynchronously, release on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_int = rst_pipe[1];

  mpx_bit_tick #(.BIT_CYCLES(BIT_CYCLES)) u_tick (
    .clk  (clk),
    .rst_n(rst_n_int),
    .tick (tick)
  );

  mpx_host_regs #(.DATA_W(DATA_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .host_wr_en(host_wr_en),
    .host_rd_en(host_rd_en),
    .host_addr (host_addr),
    .host_wdata(host_wdata),
    .host_rdata(host_rdata),
    .dma_wr_en (dma_wr_en),
    .dma_wdata (dma_wdata),
    .load      (load),
    .busy      (busy),
    .hold_data (hold_data),
    .hold_mark (hold_mark),
    .empty     (empty),
    .tend      (tend)
  );

  mpx_tx_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .tick     (tick),
    .empty    (empty),
    .hold_data(hold_data),
    .hold_mark(hold_mark),
    .load     (load),
    .busy     (busy),
    .txd      (txd)
  );

  assign txi_req = empty;
endmodule

// File: rtl/mpx_uart_tx_chk.sv
module mpx_uart_tx_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              txd,
  input logic              txi_req,
  input logic              tend,
  input logic              host_wr_en,
  input logic              host_addr,
  input logic [DATA_W-1:0] host_wdata,
  input logic              dma_wr_en,
  input logic [DATA_W-1:0] hold_data
);
  a_r1_line_rests_high: assert property (@(posedge clk) disable iff (!rst_n)
    tend |-> txd);

  a_r11_end_needs_empty: assert property (@(posedge clk) disable iff (!rst_n)
    tend |-> txi_req);

  a_r7_dma_hands_over: assert property (@(posedge clk) disable iff (!rst_n)
    (txi_req && dma_wr_en) |=> !txi_req);

  a_r6_write_one_keeps_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (txi_req && host_wr_en && host_addr && host_wdata[0] && !dma_wr_en) |=> txi_req);

  a_r8_full_holds_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (!txi_req && ((host_wr_en && !host_addr) || dma_wr_en)) |=> $stable(hold_data));
endmodule

bind mpx_uart_tx mpx_uart_tx_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .txd       (txd),
  .txi_req   (txi_req),
  .tend      (tend),
  .host_wr_en(host_wr_en),
  .host_addr (host_addr),
  .host_wdata(host_wdata),
  .dma_wr_en (dma_wr_en),
  .hold_data (hold_data)
);

// File: tb/mpx_uart_tx_test.sv
`timescale 1ns/1ps
module mpx_uart_tx_test;
  localparam int N  = 8;
  localparam int FB = 11;

  logic       clk, rst_n;
  logic       host_wr_en, host_rd_en, host_addr, dma_wr_en;
  logic [7:0] host_wdata, host_rdata, dma_wdata;
  logic       txd, txi_req;

  int n_checks = 0;
  int n_fail   = 0;
  int cycle    = 0;
  logic [8:0] exp_q[$];
  int starts[$];

  mpx_uart_tx #(.DATA_W(8), .BIT_CYCLES(N)) uut (
    .clk(clk), .rst_n(rst_n),
    .host_wr_en(host_wr_en), .host_rd_en(host_rd_en), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .dma_wr_en(dma_wr_en), .dma_wdata(dma_wdata),
    .txd(txd), .txi_req(txi_req)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;
  always @(posedge clk) cycle <= cycle + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic host_write(input logic a, input logic [7:0] d);
    @(negedge clk);
    host_wr_en = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr_en = 1'b0;
  endtask

  task automatic host_read(input logic a, output logic [7:0] d);
    @(negedge clk);
    host_rd_en = 1'b1; host_addr = a;
    #1 d = host_rdata;
    @(negedge clk);
    host_rd_en = 1'b0;
  endtask

  task automatic dma_write(input logic [7:0] d);
    @(negedge clk);
    dma_wr_en = 1'b1; dma_wdata = d;
    @(negedge clk);
    dma_wr_en = 1'b0;
  endtask

  // driver: legal hand-over, pushes the expected frame
  task automatic host_send(input logic [7:0] d, input logic mark);
    logic [7:0] s;
    s = 8'h00;
    while (!s[0]) host_read(1'b1, s);
    host_write(1'b0, d);
    host_write(1'b1, {5'b0, mark, 2'b00});
    exp_q.push_back({mark, d});
  endtask

  task automatic wait_txi();
    do @(negedge clk); while (!txi_req);
  endtask

  task automatic wait_end();
    logic [7:0] s;
    s = 8'h00;
    while (!s[1]) host_read(1'b1, s);
  endtask

  // monitor: decodes frames at mid-bit and compares against the queue
  initial begin
    logic prev;
    logic [FB-1:0] bits;
    logic [8:0] e;
    prev = 1'b1;
    forever begin
      @(negedge clk);
      if (!rst_n) prev = 1'b1;
      else if (prev && !txd) begin
        starts.push_back(cycle);
        repeat (N/2) @(negedge clk);
        bits[0] = txd;
        for (int i = 1; i < FB; i++) begin
          repeat (N) @(negedge clk);
          bits[i] = txd;
        end
        chk(bits[0] == 1'b0, "R2 start bit", bits[0], 0);
        chk(bits[FB-1] == 1'b1, "R2 stop bit", bits[FB-1], 1);
        if (exp_q.size() == 0) chk(1'b0, "R5/R7 unexpected frame", int'(bits[9:1]), 0);
        else begin
          e = exp_q.pop_front();
          chk(bits[9:1] == e, "R2/R3 frame payload", int'(bits[9:1]), int'(e));
        end
        prev = 1'b1;
      end else prev = txd;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] s;
    int base;
    rst_n = 1'b0; host_wr_en = 0; host_rd_en = 0; host_addr = 0; host_wdata = 0;
    dma_wr_en = 0; dma_wdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state, R4 layout
    chk(txd == 1'b1, "R1 line idle", txd, 1);
    chk(txi_req == 1'b1, "R1 irq", txi_req, 1);
    host_read(1'b1, s);
    chk(s == 8'h03, "R1/R4 status after reset", s, 8'h03);

    // address frame: set mark with bit0=1 (R6), then hand over
    host_write(1'b1, 8'h05);
    chk(txi_req == 1'b1, "R6 write-one keeps empty", txi_req, 1);
    host_read(1'b1, s);
    chk(s == 8'h07, "R3/R4 mark readable", s, 8'h07);
    host_write(1'b0, 8'hA5);
    host_write(1'b1, 8'h04);
    exp_q.push_back({1'b1, 8'hA5});
    chk(txi_req == 1'b0, "R9 irq drops on hand-over", txi_req, 0);
    host_read(1'b1, s);
    chk(s[1] == 1'b0, "R11 end low while pending/shifting", s[1], 0);
    wait_end();
    host_write(1'b1, 8'h01);

    // back-to-back data frames (R10), full-register write (R8)
    base = starts.size();
    host_send(8'h3C, 1'b0);
    host_send(8'h00, 1'b0);
    host_write(1'b0, 8'h99);
    host_read(1'b0, s);
    chk(s == 8'h00, "R8 host write ignored while full", s, 8'h00);
    host_send(8'hFF, 1'b0);
    wait_end();
    chk(starts.size() == base + 3, "R10 three frames", starts.size() - base, 3);
    if (starts.size() == base + 3) begin
      chk(starts[base+1] - starts[base] == FB*N, "R10 gapless 1", starts[base+1] - starts[base], FB*N);
      chk(starts[base+2] - starts[base+1] == FB*N, "R10 gapless 2", starts[base+2] - starts[base+1], FB*N);
    end
    host_read(1'b1, s);
    chk(s == 8'h03, "R11 end returns after last frame", s, 8'h03);

    // clear without a prior read (R5): hand over then wait for empty without reading
    host_send(8'h6E, 1'b0);
    wait_txi();
    host_write(1'b0, 8'h42);
    host_write(1'b1, 8'h00);
    chk(txi_req == 1'b1, "R5 clear without read ignored", txi_req, 1);
    repeat (2*FB*N) @(negedge clk);
    chk(exp_q.size() == 0, "R5 no extra frame", exp_q.size(), 0);

    // DMA path (R7)
    wait_end();
    dma_write(8'h5A);
    exp_q.push_back({1'b0, 8'h5A});
    chk(txi_req == 1'b0, "R7 dma hands over", txi_req, 0);
    wait_txi();
    dma_write(8'hC3);
    exp_q.push_back({1'b0, 8'hC3});
    dma_write(8'hEE);
    chk(txi_req == 1'b0, "R7/R9 still full", txi_req, 0);
    host_read(1'b0, s);
    chk(s == 8'hC3, "R7 dma ignored while full", s, 8'hC3);

    // mark latched at hand-over (R3)
    wait_txi();
    host_write(1'b1, 8'h05);
    dma_write(8'h81);
    exp_q.push_back({1'b1, 8'h81});
    host_write(1'b1, 8'h01);
    wait_txi();
    dma_write(8'h24);
    exp_q.push_back({1'b0, 8'h24});

    wait_end();
    repeat (N) @(negedge clk);
    chk(exp_q.size() == 0, "R2 all frames seen", exp_q.size(), 0);
    host_read(1'b1, s);
    chk(s == 8'h03, "R11/R9 final status", s, 8'h03);
    chk(txi_req == 1'b1 && txd == 1'b1, "R9 final irq and line", {txi_req, txd}, 3);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule